// File: doc/BRIEF.md
# DMA Write Target Port

This block is the peripheral side of a DMA write path. Software sets a destination start address, a word count, a target mode and a timing mode through a small register interface. When an enabled target mode is written, the block pulls its active-low request output low. An external DMA controller then pushes 16-bit words, one per acknowledged access. The block ignores any address the controller might drive and makes every destination address from its own counter.

Each accepted word goes to one of two places, chosen by the target mode. It can go to a frame-memory write port, which is given an address and a one-cycle write enable. It can instead go to a single image-data entry register, which is given a one-cycle strobe. When the programmed count has been used up, the request output returns high and a finished flag is set in the status register. Software polls that flag before it programs the next transfer.

Top module: `dma_wr_target`

## Requirements
- R1: After reset, dreq_no is 1, mem_we_o and ide_we_o are 0, and the status register (offset 7) reads 0.
- R2: A write to the control register (offset 0) with target field bits [1:0] = 01 or 11 and a non-zero count drives dreq_no low in the following cycle. It also clears the finished bit (status bit 0) and sets the busy bit (status bit 1).
- R3: A target field of 00 or 10 disables DMA. dreq_no stays high and no word is written.
- R4: With target 01, each accepted word produces one mem_we_o pulse carrying that word. The first address is the start address, with the low half at offset 1 and the high bits at offset 2. Each further word uses the previous address plus one.
- R5: With target 11, each accepted word produces one ide_we_o pulse carrying that word. mem_we_o stays low.
- R6: Exactly the count set at offsets 3 (low half) and 4 (high bits) is accepted. After the last word, dreq_no returns high and status reads 1 (finished, not busy).
- R7: Timing field bits [5:4] = 00, 01 or 11 selects single-address timing. A word is accepted on a rising edge of wr_ni while dack_ni is low. A wr_ni pulse with dack_ni high writes nothing, and cs_ni has no effect.
- R8: Timing field 10 selects dual-address timing. A word is accepted on the rising edge of dack_ni, and wr_ni is ignored.
- R9: A control-register write while a transfer is busy is ignored. The running transfer keeps its target and count.
- R10: A start with a count of 0 sets the finished bit at once and never asserts dreq_no.
- R11: The stored word is the data_i value held while the strobe was low. A change of data_i on the same clock cycle as the strobe's rising edge is not taken.
- R12: Acknowledge or write strobes that arrive while dreq_no is high write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| dreq_no | output | 1 | DMA request, active low |
| dack_ni | input | 1 | DMA acknowledge, active low |
| cs_ni | input | 1 | Chip select, active low (ignored for DMA) |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 16 | DMA write data |
| mem_we_o | output | 1 | Frame-memory write enable pulse |
| mem_addr_o | output | ADDR_W | Frame-memory write address |
| mem_wdata_o | output | 16 | Frame-memory write data |
| ide_we_o | output | 1 | Entry-register write strobe |
| ide_data_o | output | 16 | Entry-register write data |

## Verification
A remaining-count register that is off by one shows up at the ports as one write pulse too many or too few. It also makes dreq_no rise one word early, or leaves it low after the last acknowledge. Either fault is visible within the transfer being run. A wrong address counter shows on mem_addr_o at the second memory write at the latest. A wrongly latched target or timing mode moves pulses from one strobe output to the other, or drops them altogether, from the first word onward. The bench records every strobe pulse with its address and data and compares the list against the programmed values.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;
  typedef enum logic [1:0] {
    TGT_OFF_A = 2'b00,
    TGT_MEM   = 2'b01,
    TGT_OFF_B = 2'b10,
    TGT_ENTRY = 2'b11
  } tgt_mode_e;

  localparam logic [1:0] TIM_DUAL = 2'b10;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_DST_LO = 3'd1;
  localparam logic [2:0] OFS_DST_HI = 3'd2;
  localparam logic [2:0] OFS_LEN_LO = 3'd3;
  localparam logic [2:0] OFS_LEN_HI = 3'd4;
  localparam logic [2:0] OFS_STAT   = 3'd7;
endpackage

// File: rtl/dma_wr_regs.sv
module dma_wr_regs
  import dma_wr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [CNT_W-1:0]  count_o,
  output tgt_mode_e         tgt_o,
  output logic              dual_o,
  output logic              go_o,
  output logic [15:0]       rdata_o
);
  localparam int AH = ADDR_W - 16;
  localparam int CH = CNT_W - 16;

  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  count_q;
  tgt_mode_e         tgt_q;
  logic [1:0]        tim_q;
  logic              ctrl_wr;
  logic [31:0]       start_ext, count_ext;

  assign ctrl_wr = reg_we_i && (reg_addr_i == OFS_CTRL) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      count_q <= '0;
      tgt_q   <= TGT_OFF_A;
      tim_q   <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        OFS_DST_LO: start_q[15:0]        <= reg_wdata_i;
        OFS_DST_HI: start_q[ADDR_W-1:16] <= reg_wdata_i[AH-1:0];
        OFS_LEN_LO: count_q[15:0]        <= reg_wdata_i;
        OFS_LEN_HI: count_q[CNT_W-1:16]  <= reg_wdata_i[CH-1:0];
        OFS_CTRL: if (ctrl_wr) begin
          tgt_q <= tgt_mode_e'(reg_wdata_i[1:0]);
          tim_q <= reg_wdata_i[5:4];
        end
        default: ;
      endcase
    end
  end

  // enabled modes (01, 11) share bit 0
  assign go_o    = ctrl_wr && reg_wdata_i[0];
  assign start_o = start_q;
  assign count_o = count_q;
  assign tgt_o   = tgt_q;
  assign dual_o  = (tim_q == TIM_DUAL);

  assign start_ext = 32'(start_q);
  assign count_ext = 32'(count_q);

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTRL:   rdata_o = {10'd0, tim_q, 2'd0, tgt_q};
      OFS_DST_LO: rdata_o = start_ext[15:0];
      OFS_DST_HI: rdata_o = start_ext[31:16];
      OFS_LEN_LO: rdata_o = count_ext[15:0];
      OFS_LEN_HI: rdata_o = count_ext[31:16];
      OFS_STAT:   rdata_o = {14'd0, busy_i, done_i};
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_wr_strobe.sv
module dma_wr_strobe #(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ni,
  input  logic          dack_ni,
  input  logic [DW-1:0] data_i,
  input  logic          dual_i,
  output logic          word_vld_o,
  output logic [DW-1:0] word_o
);
  logic [STAGES-1:0] wr_st, dk_st;
  logic [DW-1:0]     dat_st [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_st <= '1;
      dk_st <= '1;
      for (int i = 0; i < STAGES; i++) dat_st[i] <= '0;
    end else begin
      wr_st <= {wr_st[STAGES-2:0], wr_ni};
      dk_st <= {dk_st[STAGES-2:0], dack_ni};
      dat_st[0] <= data_i;
      for (int i = 1; i < STAGES; i++) dat_st[i] <= dat_st[i-1];
    end
  end

  logic wr_rise, dk_rise;
  assign wr_rise = wr_st[STAGES-2] && !wr_st[STAGES-1];
  assign dk_rise = dk_st[STAGES-2] && !dk_st[STAGES-1];

  // single: wr rises inside ack; dual: end of ack is the write
  assign word_vld_o = dual_i ? dk_rise : (wr_rise && !dk_st[STAGES-2]);
  // oldest sample: value held while the strobe was low
  assign word_o     = dat_st[STAGES-1];
endmodule

// File: rtl/dma_wr_seq.sv
module dma_wr_seq
  import dma_wr_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  tgt_mode_e         tgt_i,
  input  logic              word_vld_i,
  input  logic [DW-1:0]     word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              ide_we_o,
  output logic [DW-1:0]     ide_data_o
);
  logic              busy_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              take;

  assign take = busy_q && word_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      addr_q      <= '0;
      left_q      <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      ide_we_o    <= 1'b0;
      ide_data_o  <= '0;
    end else begin
      mem_we_o <= 1'b0;
      ide_we_o <= 1'b0;
      if (go_i) begin
        addr_q <= start_i;
        left_q <= count_i;
        busy_q <= (count_i != '0);
        done_q <= (count_i == '0);
      end else if (take) begin
        if (tgt_i == TGT_MEM) begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= addr_q;
          mem_wdata_o <= word_i;
          addr_q      <= addr_q + ADDR_W'(1);
        end else begin
          ide_we_o   <= 1'b1;
          ide_data_o <= word_i;
        end
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/dma_wr_target.sv
module dma_wr_target
  import dma_wr_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 20,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              dreq_no,
  input  logic              dack_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [DW-1:0]     data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              ide_we_o,
  output logic [DW-1:0]     ide_data_o
);
  logic [ADDR_W-1:0] start;
  logic [CNT_W-1:0]  count;
  tgt_mode_e         tgt;
  logic              dual, go, busy, fin, word_vld;
  logic [DW-1:0]     word;
  logic              cs_unused;

  // addresses and chip select play no part in DMA writes
  assign cs_unused = cs_ni;

  dma_wr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .busy_i(busy), .done_i(fin), .start_o(start), .count_o(count),
    .tgt_o(tgt), .dual_o(dual), .go_o(go), .rdata_o(reg_rdata_o)
  );

  dma_wr_strobe #(.DW(DW), .STAGES(STAGES)) u_strobe (
    .clk_i, .rst_ni, .wr_ni, .dack_ni, .data_i, .dual_i(dual),
    .word_vld_o(word_vld), .word_o(word)
  );

  dma_wr_seq #(.DW(DW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .start_i(start), .count_i(count), .tgt_i(tgt),
    .word_vld_i(word_vld), .word_i(word), .busy_o(busy), .done_o(fin),
    .mem_we_o, .mem_addr_o, .mem_wdata_o, .ide_we_o, .ide_data_o
  );

  assign dreq_no = !busy;
endmodule

// File: rtl/dma_wr_target_chk.sv
module dma_wr_target_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dreq_no,
  input logic              fin,
  input logic              mem_we_o,
  input logic              ide_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  // R4 R5
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && ide_we_o));

  // R12
  write_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || ide_we_o) |-> $past(!dreq_no));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_no && $past(dreq_no)) |-> !(mem_we_o || ide_we_o));

  // R6
  req_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dreq_no) |-> fin);

  // R2
  req_start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dreq_no) |-> !fin);

  // R5
  entry_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ide_we_o |=> $stable(mem_addr_o));
endmodule

bind dma_wr_target dma_wr_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dreq_no(dreq_no), .fin(fin),
  .mem_we_o(mem_we_o), .ide_we_o(ide_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/dma_wr_target_tb.sv
`timescale 1ns/1ps
module dma_wr_target_tb;
  localparam int ADDR_W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic dreq_n, dack_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1;
  logic [15:0] data = '0;
  logic mem_we, ide_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0] mem_wdata, ide_data;

  int checks = 0, fails = 0;
  int n_mem = 0, n_ide = 0;
  logic [ADDR_W-1:0] log_addr [16];
  logic [15:0] log_mdat [16];
  logic [15:0] log_idat [16];

  always #4 clk = ~clk;

  dma_wr_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_no(dreq_n),
    .dack_ni(dack_n), .cs_ni(cs_n), .wr_ni(wr_n), .data_i(data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .ide_we_o(ide_we), .ide_data_o(ide_data)
  );

  always @(negedge clk) begin
    if (mem_we && n_mem < 16) begin log_addr[n_mem] = mem_addr; log_mdat[n_mem] = mem_wdata; end
    if (mem_we) n_mem++;
    if (ide_we && n_ide < 16) log_idat[n_ide] = ide_data;
    if (ide_we) n_ide++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic word_single(logic [15:0] d, logic cs);
    @(negedge clk); data = d; cs_n = cs; dack_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1; data = 16'hDEAD; // R11 late change
    repeat (3) @(negedge clk); dack_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_only(logic [15:0] d);
    @(negedge clk); data = d; wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic word_dual(logic [15:0] d);
    @(negedge clk); data = d; dack_n = 1'b0;
    repeat (3) @(negedge clk); dack_n = 1'b1; data = 16'hBEEF;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(logic [15:0] lo, logic [15:0] hi, logic [15:0] cnt);
    reg_wr(3'd1, lo); reg_wr(3'd2, hi); reg_wr(3'd3, cnt); reg_wr(3'd4, 16'h0);
    n_mem = 0; n_ide = 0;
  endtask

  task automatic t_reset;
    logic [15:0] s;
    chk("R1 dreq", 32'(dreq_n), 1);
    chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 ide_we", 32'(ide_we), 0);
    reg_rd(3'd7, s); chk("R1 status", 32'(s), 0);
  endtask

  task automatic t_mem_single;
    logic [15:0] s;
    setup(16'h3456, 16'h0012, 16'd3);
    reg_wr(3'd0, 16'h0001);
    chk("R2 dreq low", 32'(dreq_n), 0);
    reg_rd(3'd7, s); chk("R2 status busy", 32'(s), 2);
    wr_only(16'h1111);             // R7 strobe without ack
    chk("R7 no write w/o ack", 32'(n_mem), 0);
    word_single(16'hA001, 1'b1);   // R7 cs high ignored
    word_single(16'hA002, 1'b0);
    chk("R6 not early", 32'(dreq_n), 0);
    word_single(16'hA003, 1'b1);
    chk("R6 count", 32'(n_mem), 3);
    chk("R4 addr0", 32'(log_addr[0]), 32'h123456);
    chk("R4 addr1", 32'(log_addr[1]), 32'h123457);
    chk("R4 addr2", 32'(log_addr[2]), 32'h123458);
    chk("R11 data0", 32'(log_mdat[0]), 32'hA001);
    chk("R4 data2", 32'(log_mdat[2]), 32'hA003);
    chk("R5 no entry", 32'(n_ide), 0);
    chk("R6 dreq high", 32'(dreq_n), 1);
    reg_rd(3'd7, s); chk("R6 status", 32'(s), 1);
  endtask

  task automatic t_entry_dual;
    setup(16'h0100, 16'h0000, 16'd2);
    reg_wr(3'd0, 16'h0023);
    wr_only(16'h2222);             // R8 wr ignored in dual
    chk("R8 wr ignored", 32'(n_ide), 0);
    word_dual(16'hC001);
    word_dual(16'hC002);
    chk("R5 entry count", 32'(n_ide), 2);
    chk("R5 entry data0", 32'(log_idat[0]), 32'hC001);
    chk("R8 entry data1", 32'(log_idat[1]), 32'hC002);
    chk("R5 no mem", 32'(n_mem), 0);
    chk("R6 dreq high", 32'(dreq_n), 1);
  endtask

  task automatic t_busy_ignore;
    setup(16'h0040, 16'h0000, 16'd2);
    reg_wr(3'd0, 16'h0001);
    reg_wr(3'd0, 16'h0023);        // R9 must be ignored
    word_single(16'hB001, 1'b1);
    word_single(16'hB002, 1'b1);
    chk("R9 stays mem", 32'(n_mem), 2);
    chk("R9 no entry", 32'(n_ide), 0);
    chk("R9 addr", 32'(log_addr[1]), 32'h41);
  endtask

  task automatic t_disabled;
    setup(16'h0000, 16'h0000, 16'd4);
    reg_wr(3'd0, 16'h0000);
    chk("R3 mode00 dreq", 32'(dreq_n), 1);
    word_single(16'hE001, 1'b0);
    reg_wr(3'd0, 16'h0002);
    chk("R3 mode10 dreq", 32'(dreq_n), 1);
    word_dual(16'hE002);
    chk("R12 no writes", 32'(n_mem + n_ide), 0);
  endtask

  task automatic t_zero;
    logic [15:0] s;
    setup(16'h0000, 16'h0000, 16'd0);
    reg_wr(3'd0, 16'h0001);
    chk("R10 dreq", 32'(dreq_n), 1);
    reg_rd(3'd7, s); chk("R10 status", 32'(s), 1);
    word_single(16'hF001, 1'b0);
    chk("R12 idle ack", 32'(n_mem), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mem_single;
    t_entry_dual;
    t_busy_ignore;
    t_disabled;
    t_zero;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule